// File: doc/BRIEF.md
# Byte-Serial Masked AES Round Sequencer

This block keeps the 128-bit AES state as two XOR shares. Each share sits in a 16-stage byte shift register. A controller walks the state through every round one byte at a time. Each cycle it presents one byte of each share, with the round-key byte already added to the first share, to an external three-stage pipelined inverter. The inverter's two result shares enter the tail of the array after a fixed latency. The linear part of the S-box, ShiftRows and MixColumns are all applied inside the array, so only the field inversion leaves the block.

The schedule is compressed so that a round takes 20 cycles. Two overlaps make this possible. The cycle that writes the last substituted byte also applies the ShiftRows permutation, through one merged shift path. Three of the four MixColumns columns are mixed while the next round is already feeding bytes to the inverter, so only the first column takes a cycle of its own. The final round skips MixColumns. The 16 result bytes are then shifted out with the last round key added. A one-cycle pulse marks the first output byte. Round keys come from outside, byte by byte, at an index the block announces.

The shares are loaded before the start command. The caller combines them outside the block: share 0 is the plaintext XOR a random mask, and share 1 is the mask. All arithmetic uses the basis that the external inverter expects. The default basis is the plain AES polynomial basis, with reduction constant 0x1B and affine constant 0x63.

Top module: `aes_bs_state`

## Requirements
- R1: While reset is held and after it is released, `outValid`, `done` and `invValid` are 0 and `dataOut` is 0 until an encryption reaches its output phase.
- R2: While idle, each cycle with `loadValid` high shifts one byte pair into the tail of the two shares. After 16 loads the first byte loaded is state byte 0. It is therefore the first byte sent in round 1: `invTap0` = share0 byte 0 XOR key byte 0.
- R3: The 16 output bytes equal AES encryption, with `NumRounds` rounds, of the plaintext share0 XOR share1 under the round keys supplied on `keyByte`. State byte i is row i mod 4, column i div 4.
- R4: For the default `NumRounds`=10 and `InvLatency`=3, every round except the last lasts 20 cycles. `done` is seen in the cycle that follows the 199th clock edge after the edge that samples `start`.
- R5: `invValid` is high for 16 consecutive cycles in each round, sending state bytes 0..15 in order (160 sends per encryption). The two result shares of a send are taken from `invRet0`/`invRet1` exactly `InvLatency` cycles later.
- R6: During a send in round r (counted from 1), `keyRound` = r-1 and `keyIdx` is the byte being sent. During output, `keyRound` = `NumRounds` and `keyIdx` is the byte being output.
- R7: The key is added to share 0 only. In the first send of round 1, `invTap1` equals the share-1 byte 0 that was loaded. The ciphertext does not depend on the mask value.
- R8: `loadValid` pulses while an encryption is running have no effect on the result.
- R9: A `start` pulse while an encryption is running is ignored: it restarts nothing and the completion time does not change.
- R10: The output phase holds `outValid` high for exactly 16 consecutive cycles. It presents bytes 0..15 in order, and `dataOut` = share0 XOR share1 XOR the final round-key byte.
- R11: `done` is a one-cycle pulse that coincides with the first output byte (`outValid` high, `keyIdx` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load one share byte pair (idle only) |
| loadShare0 | input | 8 | Share 0 load byte |
| loadShare1 | input | 8 | Share 1 load byte |
| start | input | 1 | Begin encryption of the loaded state |
| keyByte | input | 8 | Round-key byte selected by keyRound/keyIdx |
| keyRound | output | $clog2(NumRounds+1) | Round-key number being requested |
| keyIdx | output | 4 | Byte index within the requested round key |
| invValid | output | 1 | Inverter tap carries a byte this cycle |
| invTap0 | output | 8 | Share 0 to inverter (key added) |
| invTap1 | output | 8 | Share 1 to inverter |
| invRet0 | input | 8 | Inverter result share 0 |
| invRet1 | input | 8 | Inverter result share 1 |
| outValid | output | 1 | dataOut carries a ciphertext byte |
| dataOut | output | 8 | Unmasked ciphertext byte |
| done | output | 1 | Pulse with the first ciphertext byte |

## Verification
Two pairs of work share a cycle. In the substitution phase, the last inverter return enters the array in the same cycle as the ShiftRows permutation. At the start of each round from round 2 on, the MixColumns writes for columns 1 to 3 land in the same cycles as the first three inverter sends. Every known-answer encryption exercises both overlaps in every round. A wrong position in the merged write, or in the shifted MixColumns write, corrupts specific ciphertext bytes, and the 128-bit comparison against the expected value catches that. The cycle count from `start` to `done` confirms that the overlaps really save the cycles.

// File: rtl/aes_bs_pkg.sv
package aes_bs_pkg;

  localparam int ByteW      = 8;
  localparam int NumBytes   = 16;
  localparam int ColBytes   = 4;
  localparam int IdxW       = $clog2(NumBytes);
  localparam logic [ByteW-1:0] ReducePoly = 8'h1B;
  localparam logic [ByteW-1:0] AffConst   = 8'h63;

  typedef logic [ByteW-1:0] byte_t;

  typedef enum logic [1:0] {PhIdle, PhRun, PhOut} phase_e;

  // strobes seen by one share lane
  typedef struct packed {
    logic       loadEn;
    logic       shiftEn;
    logic       srEn;
    logic       mixEn;
    logic       mixShift;
    logic [1:0] mixSel;
    logic       outEn;
  } lane_ctl_t;

  typedef struct packed {
    lane_ctl_t lane;
    logic      sendEn;
  } ctl_t;

  function automatic byte_t xtime(input byte_t a);
    return {a[ByteW-2:0], 1'b0} ^ (a[ByteW-1] ? ReducePoly : '0);
  endfunction

  function automatic byte_t rotl(input byte_t a, input int n);
    byte_t r;
    for (int b = 0; b < ByteW; b++) r[(b + n) % ByteW] = a[b];
    return r;
  endfunction

  // linear part of the S-box affine map (constant added by lane 0 only)
  function automatic byte_t affLin(input byte_t a);
    byte_t r;
    r = a;
    for (int k = 1; k <= 4; k++) r = r ^ rotl(a, k);
    return r;
  endfunction

  // source index of state byte i under ShiftRows (column-major order)
  function automatic logic [IdxW-1:0] srSrc(input int i);
    int c;
    int r;
    c = i / ColBytes;
    r = i % ColBytes;
    return IdxW'(ColBytes * ((c + r) % ColBytes) + r);
  endfunction

  // one column; a[7:0] is row 0
  function automatic logic [4*ByteW-1:0] mixCol(input logic [4*ByteW-1:0] a);
    byte_t a0, a1, a2, a3;
    a0 = a[0 +: ByteW];
    a1 = a[ByteW +: ByteW];
    a2 = a[2*ByteW +: ByteW];
    a3 = a[3*ByteW +: ByteW];
    return {xtime(a3) ^ xtime(a0) ^ a0 ^ a1 ^ a2,
            xtime(a2) ^ xtime(a3) ^ a3 ^ a0 ^ a1,
            xtime(a1) ^ xtime(a2) ^ a2 ^ a3 ^ a0,
            xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3};
  endfunction

endpackage

// File: rtl/aes_bs_lane.sv
module aes_bs_lane
  import aes_bs_pkg::*;
#(
  parameter bit IsLead = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  lane_ctl_t ctl,
  input  byte_t     loadByte,
  input  byte_t     retByte,
  output byte_t     headByte
);

  byte_t st  [NumBytes];
  byte_t nxt [NumBytes];
  byte_t shf [NumBytes];
  byte_t tailIn;
  logic [IdxW-1:0] baseIdx;
  logic [IdxW-1:0] wIdx;
  logic [4*ByteW-1:0] colIn;
  logic [4*ByteW-1:0] colOut;

  always_comb begin
    case (ctl.mixSel)
      2'd0:    baseIdx = IdxW'(0);
      2'd1:    baseIdx = IdxW'(4);
      2'd2:    baseIdx = IdxW'(7);
      default: baseIdx = IdxW'(10);
    endcase
  end

  // MixColumns input gated to zero when idle
  always_comb begin
    for (int k = 0; k < ColBytes; k++)
      colIn[k*ByteW +: ByteW] = ctl.mixEn ? st[baseIdx + IdxW'(k)] : '0;
  end

  assign colOut = mixCol(colIn);

  always_comb begin
    tailIn = ctl.loadEn ? loadByte
                        : (affLin(retByte) ^ (IsLead ? AffConst : byte_t'(0)));
    for (int i = 0; i < NumBytes - 1; i++) shf[i] = st[i+1];
    shf[NumBytes-1] = tailIn;
    for (int i = 0; i < NumBytes; i++) nxt[i] = st[i];
    if (ctl.loadEn || ctl.shiftEn || ctl.outEn)
      for (int i = 0; i < NumBytes; i++) nxt[i] = shf[i];
    // merged path: last substitution plus ShiftRows in one write
    if (ctl.srEn)
      for (int i = 0; i < NumBytes; i++) nxt[i] = shf[srSrc(i)];
    wIdx = '0;
    if (ctl.mixEn) begin
      for (int k = 0; k < ColBytes; k++) begin
        wIdx = baseIdx + IdxW'(k) - {{(IdxW-1){1'b0}}, ctl.mixShift};
        nxt[wIdx] = colOut[k*ByteW +: ByteW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumBytes; i++) st[i] <= '0;
    end else begin
      for (int i = 0; i < NumBytes; i++) st[i] <= nxt[i];
    end
  end

  assign headByte = st[0];

  // R4: the merged ShiftRows write never meets a MixColumns write
  a_r4_mix_sr_apart: assert property (@(posedge clk) disable iff (!rstN)
    ctl.srEn |-> !ctl.mixEn);

endmodule

// File: rtl/aes_bs_datapath.sv
module aes_bs_datapath
  import aes_bs_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  ctl_t  ctl,
  input  byte_t loadShare0,
  input  byte_t loadShare1,
  input  byte_t keyByte,
  input  byte_t invRet0,
  input  byte_t invRet1,
  output byte_t invTap0,
  output byte_t invTap1,
  output byte_t dataOut
);

  localparam int NumShares = 2;

  byte_t loadB [NumShares];
  byte_t retB  [NumShares];
  byte_t headB [NumShares];

  assign loadB[0] = loadShare0;
  assign loadB[1] = loadShare1;
  assign retB[0]  = invRet0;
  assign retB[1]  = invRet1;

  for (genvar g = 0; g < NumShares; g++) begin : g_share
    aes_bs_lane #(.IsLead(g == 0)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl.lane),
      .loadByte (loadB[g]),
      .retByte  (retB[g]),
      .headByte (headB[g])
    );
  end

  // round key joins share 0 only
  assign invTap0 = ctl.sendEn ? (headB[0] ^ keyByte) : '0;
  assign invTap1 = ctl.sendEn ? headB[1] : '0;
  assign dataOut = ctl.lane.outEn ? (headB[0] ^ headB[1] ^ keyByte) : '0;

  // R2: loading excludes every other state write
  a_r2_load_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lane.loadEn |-> !(ctl.lane.shiftEn || ctl.lane.mixEn || ctl.lane.outEn || ctl.sendEn));

endmodule

// File: rtl/aes_bs_ctrl.sv
module aes_bs_ctrl
  import aes_bs_pkg::*;
#(
  parameter int NumRounds  = 10,
  parameter int InvLatency = 3,
  localparam int RndW      = $clog2(NumRounds + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            loadValid,
  output ctl_t            ctl,
  output logic [RndW-1:0] keyRound,
  output logic [IdxW-1:0] keyIdx,
  output logic            invValid,
  output logic            outValid,
  output logic            done
);

  localparam int SrCycle  = NumBytes + InvLatency - 1;
  localparam int RoundLen = SrCycle + 2;
  localparam int CycW     = $clog2(RoundLen);

  phase_e          phase;
  logic [CycW-1:0] cyc;
  logic [RndW-1:0] rnd;
  logic            lastRound;
  logic            atSr;
  logic            atEnd;

  assign lastRound = (rnd == RndW'(NumRounds));
  assign atSr      = (cyc == CycW'(SrCycle));
  assign atEnd     = (cyc == CycW'(RoundLen - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PhIdle;
      cyc   <= '0;
      rnd   <= '0;
    end else begin
      case (phase)
        PhIdle: if (start) begin
          phase <= PhRun;
          cyc   <= '0;
          rnd   <= RndW'(1);
        end
        PhRun: begin
          if (atSr && lastRound) begin
            phase <= PhOut;
            cyc   <= '0;
          end else if (atEnd) begin
            cyc <= '0;
            rnd <= rnd + RndW'(1);
          end else begin
            cyc <= cyc + CycW'(1);
          end
        end
        default: begin
          if (cyc == CycW'(NumBytes - 1)) begin
            phase <= PhIdle;
            cyc   <= '0;
            rnd   <= '0;
          end else begin
            cyc <= cyc + CycW'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    case (phase)
      PhIdle: ctl.lane.loadEn = loadValid;
      PhRun: begin
        ctl.sendEn       = (cyc < CycW'(NumBytes));
        ctl.lane.shiftEn = (cyc <= CycW'(SrCycle));
        ctl.lane.srEn    = atSr;
        if (atEnd) begin
          ctl.lane.mixEn  = 1'b1;
          ctl.lane.mixSel = 2'd0;
        end else if (rnd > RndW'(1) && cyc < CycW'(3)) begin
          // remaining columns of the previous round, mixed while shifting
          ctl.lane.mixEn    = 1'b1;
          ctl.lane.mixShift = 1'b1;
          ctl.lane.mixSel   = cyc[1:0] + 2'd1;
        end
      end
      default: ctl.lane.outEn = 1'b1;
    endcase
  end

  always_comb begin
    case (phase)
      PhRun:   keyRound = rnd - RndW'(1);
      PhOut:   keyRound = RndW'(NumRounds);
      default: keyRound = '0;
    endcase
  end

  assign keyIdx   = cyc[IdxW-1:0];
  assign invValid = ctl.sendEn;
  assign outValid = ctl.lane.outEn;
  assign done     = (phase == PhOut) && (cyc == '0);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_first_byte: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outValid && keyIdx == '0));

  a_r4_round_advance: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhRun && atEnd) |=> (phase == PhRun && cyc == '0 && rnd == $past(rnd) + RndW'(1)));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhRun && start) |=> !(phase == PhRun && cyc == '0 && rnd == RndW'(1)));

  a_r10_out_ends: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhOut && cyc == CycW'(NumBytes - 1)) |=> !outValid);

endmodule

// File: rtl/aes_bs_state.sv
module aes_bs_state
  import aes_bs_pkg::*;
#(
  parameter int NumRounds  = 10,
  parameter int InvLatency = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               loadValid,
  input  logic [ByteW-1:0]                   loadShare0,
  input  logic [ByteW-1:0]                   loadShare1,
  input  logic                               start,
  input  logic [ByteW-1:0]                   keyByte,
  output logic [$clog2(NumRounds+1)-1:0]     keyRound,
  output logic [IdxW-1:0]                    keyIdx,
  output logic                               invValid,
  output logic [ByteW-1:0]                   invTap0,
  output logic [ByteW-1:0]                   invTap1,
  input  logic [ByteW-1:0]                   invRet0,
  input  logic [ByteW-1:0]                   invRet1,
  output logic                               outValid,
  output logic [ByteW-1:0]                   dataOut,
  output logic                               done
);

  ctl_t ctl;

  aes_bs_ctrl #(.NumRounds(NumRounds), .InvLatency(InvLatency)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .loadValid (loadValid),
    .ctl       (ctl),
    .keyRound  (keyRound),
    .keyIdx    (keyIdx),
    .invValid  (invValid),
    .outValid  (outValid),
    .done      (done)
  );

  aes_bs_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .loadShare0 (loadShare0),
    .loadShare1 (loadShare1),
    .keyByte    (keyByte),
    .invRet0    (invRet0),
    .invRet1    (invRet1),
    .invTap0    (invTap0),
    .invTap1    (invTap1),
    .dataOut    (dataOut)
  );

endmodule

// File: tb/aes_bs_state_tb.sv
module aes_bs_state_tb;

  localparam int NR  = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, loadValid, start;
  logic [7:0] loadShare0, loadShare1, keyByte;
  logic [3:0] keyRound, keyIdx;
  logic       invValid, outValid, done;
  logic [7:0] invTap0, invTap1, invRet0, invRet1, dataOut;

  aes_bs_state #(.NumRounds(NR), .InvLatency(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadShare0(loadShare0),
    .loadShare1(loadShare1), .start(start), .keyByte(keyByte), .keyRound(keyRound),
    .keyIdx(keyIdx), .invValid(invValid), .invTap0(invTap0), .invTap1(invTap1),
    .invRet0(invRet0), .invRet1(invRet1), .outValid(outValid), .dataOut(dataOut),
    .done(done)
  );

  int total = 0;
  int bad = 0;

  logic [7:0] rk [0:NR][0:15];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int c = 1; c < 256; c++)
      if (gmul(a, 8'(c)) == 8'h01) r = 8'(c);
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] x = ginv(a);
    return x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]} ^ 8'h63;
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:4*NR+3];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 4*NR+4; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0]), sbox(t[31:24])} ^ {rc, 24'h0};
        rc = gmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 4; b++)
          rk[r][4*c+b] = w[4*r+c][31-8*b -: 8];
  endtask

  assign keyByte = (keyRound <= 4'(NR)) ? rk[keyRound][keyIdx] : 8'h00;

  // unmasked inverter model: three registers, fresh re-sharing mask
  logic [7:0] p0 [LAT];
  logic [7:0] p1 [LAT];
  logic [7:0] rm;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rm <= 8'h5A;
      for (int k = 0; k < LAT; k++) begin
        p0[k] <= 8'h00;
        p1[k] <= 8'h00;
      end
    end else begin
      rm    <= rm + 8'h2D;
      p0[0] <= ginv(invTap0 ^ invTap1) ^ rm;
      p1[0] <= rm;
      for (int k = 1; k < LAT; k++) begin
        p0[k] <= p0[k-1];
        p1[k] <= p1[k-1];
      end
    end
  end
  assign invRet0 = p0[LAT-1];
  assign invRet1 = p1[LAT-1];

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_enc(input logic [127:0] pt, input logic [127:0] key,
                         input logic [127:0] exp, input logic [7:0] seed,
                         input bit junkLoad, input bit junkStart, input string tag);
    logic [7:0]   mask [16];
    logic [127:0] ct = '0;
    int cnt = 0, sends = 0, outs = 0, seqBad = 0, doneAt = -1, doneCnt = 0;
    int firstOut = -1, lastOut = -1;
    expand(key);
    for (int i = 0; i < 16; i++) mask[i] = seed * 8'h3B + 8'(i) * 8'h17;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      loadValid  = 1'b1;
      loadShare1 = mask[i];
      loadShare0 = pt[127-8*i -: 8] ^ mask[i];
    end
    @(negedge clk);
    loadValid = 1'b0;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (outs < 16 && cnt < 1000) begin
      if (invValid) begin
        if (keyRound != 4'(sends / 16) || keyIdx != 4'(sends % 16)) seqBad++;
        if (sends == 0) begin
          check(invTap1 == mask[0], {tag, " R7 share1 tap"}, 128'(invTap1), 128'(mask[0]));
          check(invTap0 == (pt[127:120] ^ mask[0] ^ rk[0][0]), {tag, " R2 first tap"},
                128'(invTap0), 128'(pt[127:120] ^ mask[0] ^ rk[0][0]));
        end
        sends++;
      end
      if (done) begin
        doneCnt++;
        if (doneAt < 0) doneAt = cnt;
      end
      if (outValid) begin
        if (keyRound != 4'(NR) || keyIdx != 4'(outs)) seqBad++;
        if (firstOut < 0) firstOut = cnt;
        lastOut = cnt;
        ct[127-8*outs -: 8] = dataOut;
        outs++;
      end
      if (junkLoad) begin
        loadValid  = 1'b1;
        loadShare0 = 8'(cnt * 7 + 3);
        loadShare1 = 8'(cnt * 13 + 1);
      end
      start = junkStart && (cnt == 57 || cnt == 190);
      @(negedge clk);
      cnt++;
    end
    loadValid = 1'b0;
    start     = 1'b0;
    check(ct == exp, {tag, " R3 ciphertext"}, ct, exp);
    check(doneAt == 20*NR-1, {tag, " R4 done cycle"}, 128'(doneAt), 128'(20*NR-1));
    check(sends == 16*NR, {tag, " R5 inverter sends"}, 128'(sends), 128'(16*NR));
    check(seqBad == 0, {tag, " R6 key request order"}, 128'(seqBad), 128'(0));
    check(outs == 16 && lastOut - firstOut == 15, {tag, " R10 output burst"},
          128'(lastOut - firstOut), 128'(15));
    check(doneCnt == 1 && doneAt == firstOut, {tag, " R11 done pulse"},
          128'(doneCnt), 128'(1));
    repeat (3) @(negedge clk);
  endtask

  // plaintext, key, expected ciphertext
  localparam logic [383:0] VECS [3] = '{
    {128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadValid = 1'b0; start = 1'b0;
    loadShare0 = 8'h00; loadShare1 = 8'h00;
    for (int r = 0; r <= NR; r++)
      for (int b = 0; b < 16; b++) rk[r][b] = 8'h00;
    repeat (3) @(negedge clk);
    check(!outValid && !done && !invValid && dataOut == 8'h00, "R1 reset held",
          128'({outValid, done, invValid}), 128'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!outValid && !done && !invValid && dataOut == 8'h00, "R1 after reset",
          128'({outValid, done, invValid}), 128'(0));

    for (int v = 0; v < 3; v++)
      run_enc(VECS[v][383:256], VECS[v][255:128], VECS[v][127:0], 8'(v + 1), 1'b0, 1'b0,
              $sformatf("vec%0d", v));

    // R7: same input under a different mask
    run_enc(VECS[1][383:256], VECS[1][255:128], VECS[1][127:0], 8'hC4, 1'b0, 1'b0, "R7 remask");
    // R8: load strobes during the run
    run_enc(VECS[0][383:256], VECS[0][255:128], VECS[0][127:0], 8'h21, 1'b1, 1'b0, "R8 load busy");
    // R9: start pulses during the run
    run_enc(VECS[2][383:256], VECS[2][255:128], VECS[2][127:0], 8'h77, 1'b0, 1'b1, "R9 start busy");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule